// File: doc/BRIEF.md
# Machine-Check Classifier and Interruption Priority Selector

This block receives error reports from the retry controller, the storage error-correction logic and the channel paths. It sorts each report into a hard (critical) or soft (recovered) machine check and forms the 16-bit machine-check interruption code. It then selects one winner per cycle among five interruption classes: hard machine check, program or supervisor call, soft machine check, external, and I/O.

A hard check is requested as soon as it is recorded. A soft check waits until the CPU signals the end of the current operation. While the machine-check mask is closed, reports are kept in a single pending slot rather than being interrupted on. When the mask reopens, exactly one machine check is delivered. A critical report displaces a recovered one, and all other reports are dropped. Each class has an enable, and a disabled class is passed over.

The grant is a registered one-hot vector that lasts one cycle. The interruption code is registered with a machine-check grant and holds its value until the next one.

Top module: `mchk_intr_ctl`

## Requirements
- R1: `err_kind` maps to `mc_code` as follows: 0 (retry succeeded) gives 0x0009, 1 (retry exhausted after seven tries) gives 0x0001, 2 (not retriable) gives 0x0004, 3 (ECC corrected) gives 0x0008, 4 (channel uncorrectable) gives 0x001A, 5 (CPU uncorrectable, retry succeeded) gives 0x0019, 6 (CPU uncorrectable, retry exhausted) gives 0x0011, 7 (CPU uncorrectable, not retriable) gives 0x0014. Result codes 1 and 4 are hard; 8, 9 and 10 are soft.
- R2: Code bit n (numbered 16 to 31) is `mc_code[31-n]`. Bits 16 to 26 are always 0. Bit 27 (`mc_code[4]`) marks a multi-bit storage data error. `mc_code` loads only on a machine-check grant and holds its value otherwise.
- R3: With the mask open and class 0 enabled, a hard report sampled at clock edge k is granted on `grant[0]` after edge k+1.
- R4: A soft machine check is granted only after an edge at which `op_end` was 1. A soft report that is already pending is granted one edge after `op_end` is sampled high.
- R5: Grant bit indices are 0 hard, 1 program/SVC, 2 soft, 3 external, 4 I/O. The lower index wins among concurrent requests.
- R6: A class whose `class_en` bit is 0 is never granted. Lower-priority requests are served in its place, and its pending machine check remains held.
- R7: While `mc_mask` is 0, no machine-check grant is issued and reports stay pending.
- R8: Reports recorded while a machine check is pending collapse into one interruption. A hard report replaces a pending soft one. Any other later report is discarded, so the first hard report, or else the first soft report, is the one kept.
- R9: `grant` has at most one bit set. A pending machine check is cleared by its own grant, so it is granted only once.
- R10: A synchronous reset (`rst_n` low) clears the pending report, `grant` and `mc_code`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| err_vld | input | 1 | Error report present this cycle |
| err_kind | input | 3 | Error report type (see R1) |
| op_end | input | 1 | Current operation ends this cycle |
| mc_mask | input | 1 | Machine-check mask, 1 = allowed |
| class_en | input | 5 | Per-class enable, indexed as grant |
| req_pgm | input | 1 | Program or supervisor-call request |
| req_ext | input | 1 | External interruption request |
| req_io | input | 1 | I/O interruption request |
| grant | output | 5 | One-hot grant, one cycle |
| mc_code | output | 16 | Machine-check interruption code |

## Verification
The assertions assume that `mc_mask`, `op_end` and `class_en` are levels sampled once per cycle. They also assume that the program, external and I/O requesters hold their lines until granted and then drop them, so a held request is granted again on every cycle it stays asserted. The stimulus changes inputs only at the falling clock edge. It holds each external request for exactly the cycles that the expected grant sequence needs. It reaches the masked, deferred and disabled situations only by way of reports and levels that the block accepts through its normal ports.

// File: rtl/mchk_pkg.sv
// Shared constants and types for the machine-check classifier.
// Assumes a 4-bit result field directly below a single multi-bit flag.
package mchk_pkg;
    localparam int N_CLASS = 5;
    localparam int CODE_W  = 16;
    localparam int RES_W   = 4;

    localparam int CL_HARD = 0;
    localparam int CL_PGM  = 1;
    localparam int CL_SOFT = 2;
    localparam int CL_EXT  = 3;
    localparam int CL_IO   = 4;

    localparam logic [RES_W-1:0] RES_RETRY_FAIL = 4'd1;
    localparam logic [RES_W-1:0] RES_NO_RETRY   = 4'd4;
    localparam logic [RES_W-1:0] RES_ECC_FIXED  = 4'd8;
    localparam logic [RES_W-1:0] RES_RETRY_OK   = 4'd9;
    localparam logic [RES_W-1:0] RES_INTERCEPT  = 4'd10;

    typedef enum logic [2:0] {
        EK_RETRY_OK     = 3'd0,
        EK_RETRY_FAIL   = 3'd1,
        EK_NO_RETRY     = 3'd2,
        EK_ECC_FIXED    = 3'd3,
        EK_CHAN_UNCORR  = 3'd4,
        EK_CPU_UNC_OK   = 3'd5,
        EK_CPU_UNC_FAIL = 3'd6,
        EK_CPU_UNC_NORT = 3'd7
    } err_kind_e;

    typedef struct packed {
        logic             hard;
        logic             mbit;
        logic [RES_W-1:0] res;
    } mc_rec_t;
endpackage

// File: rtl/mc_classify.sv
// Maps an error report type to a hard/soft flag, multi-bit flag and result.
// Assumes every 3-bit value is a defined report type (all eight are used).
module mc_classify
    import mchk_pkg::*;
(
    input  logic [2:0] kind_i,
    output mc_rec_t    rec_o
);
    // Decode the report type into its interruption record.
    always_comb begin
        rec_o = '0;
        unique case (err_kind_e'(kind_i))
            EK_RETRY_OK:     rec_o = '{hard: 1'b0, mbit: 1'b0, res: RES_RETRY_OK};
            EK_RETRY_FAIL:   rec_o = '{hard: 1'b1, mbit: 1'b0, res: RES_RETRY_FAIL};
            EK_NO_RETRY:     rec_o = '{hard: 1'b1, mbit: 1'b0, res: RES_NO_RETRY};
            EK_ECC_FIXED:    rec_o = '{hard: 1'b0, mbit: 1'b0, res: RES_ECC_FIXED};
            EK_CHAN_UNCORR:  rec_o = '{hard: 1'b0, mbit: 1'b1, res: RES_INTERCEPT};
            EK_CPU_UNC_OK:   rec_o = '{hard: 1'b0, mbit: 1'b1, res: RES_RETRY_OK};
            EK_CPU_UNC_FAIL: rec_o = '{hard: 1'b1, mbit: 1'b1, res: RES_RETRY_FAIL};
            EK_CPU_UNC_NORT: rec_o = '{hard: 1'b1, mbit: 1'b1, res: RES_NO_RETRY};
            default:         rec_o = '0;
        endcase
    end
endmodule

// File: rtl/mc_pending.sv
// Single-slot holding register for machine checks awaiting delivery.
// A hard report displaces a held soft one; all other late reports are lost.
// Assumes clear_i is asserted only in a cycle where the held check is granted.
module mc_pending
    import mchk_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    new_vld_i,
    input  mc_rec_t new_rec_i,
    input  logic    clear_i,
    output logic    pend_vld_o,
    output mc_rec_t pend_rec_o
);
    logic    base_vld;
    mc_rec_t base_rec;
    logic    nxt_vld;
    mc_rec_t nxt_rec;

    // Remove a granted check, then merge in the new report.
    always_comb begin
        base_vld = pend_vld_o & ~clear_i;
        base_rec = clear_i ? '0 : pend_rec_o;
        nxt_vld  = base_vld;
        nxt_rec  = base_rec;
        if (new_vld_i && (!base_vld || (new_rec_i.hard && !base_rec.hard))) begin
            nxt_vld = 1'b1;
            nxt_rec = new_rec_i;
        end
    end

    // Hold state with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_vld_o <= 1'b0;
            pend_rec_o <= '0;
        end else begin
            pend_vld_o <= nxt_vld;
            pend_rec_o <= nxt_rec;
        end
    end
endmodule

// File: rtl/int_prio_arb.sv
// Fixed-priority selector: index 0 has the highest priority.
// Assumes the requests are already qualified by enables and masks.
module int_prio_arb #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] gnt_o
);
    logic [N:0] taken;

    assign taken[0] = 1'b0;

    // One stage per class: grant if requested and nobody above has won.
    for (genvar i = 0; i < N; i++) begin : g_stage
        assign gnt_o[i]     = req_i[i] & ~taken[i];
        assign taken[i + 1] = taken[i] | req_i[i];
    end
endmodule

// File: rtl/mchk_intr_ctl.sv
// Top: classifies error reports, keeps one pending machine check and
// selects one of five interruption classes per cycle.
// Assumes requesters hold req_* until they see their grant bit.
module mchk_intr_ctl
    import mchk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_vld,
    input  logic [2:0]        err_kind,
    input  logic              op_end,
    input  logic              mc_mask,
    input  logic [N_CLASS-1:0] class_en,
    input  logic              req_pgm,
    input  logic              req_ext,
    input  logic              req_io,
    output logic [N_CLASS-1:0] grant,
    output logic [CODE_W-1:0] mc_code
);
    localparam int PAD_W = CODE_W - RES_W - 1;

    mc_rec_t            new_rec;
    mc_rec_t            pend_rec;
    logic               pend_vld;
    logic [N_CLASS-1:0] req_vec;
    logic [N_CLASS-1:0] gnt_c;
    logic               mc_take;

    mc_classify u_cls (
        .kind_i (err_kind),
        .rec_o  (new_rec)
    );

    mc_pending u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .new_vld_i  (err_vld),
        .new_rec_i  (new_rec),
        .clear_i    (mc_take),
        .pend_vld_o (pend_vld),
        .pend_rec_o (pend_rec)
    );

    // Qualify each class request by its enable, the mask and operation end.
    always_comb begin
        req_vec          = '0;
        req_vec[CL_HARD] = pend_vld & pend_rec.hard & mc_mask;
        req_vec[CL_PGM]  = req_pgm;
        req_vec[CL_SOFT] = pend_vld & ~pend_rec.hard & mc_mask & op_end;
        req_vec[CL_EXT]  = req_ext;
        req_vec[CL_IO]   = req_io;
        req_vec          = req_vec & class_en;
    end

    int_prio_arb #(.N(N_CLASS)) u_arb (
        .req_i (req_vec),
        .gnt_o (gnt_c)
    );

    assign mc_take = gnt_c[CL_HARD] | gnt_c[CL_SOFT];

    // Register the grant pulse and capture the code on a machine-check win.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant   <= '0;
            mc_code <= '0;
        end else begin
            grant <= gnt_c;
            if (mc_take) begin
                mc_code <= {{PAD_W{1'b0}}, pend_rec.mbit, pend_rec.res};
            end
        end
    end
endmodule

// File: rtl/mchk_intr_chk.sv
// Property checker bound to mchk_intr_ctl; observes ports and pending state.
module mchk_intr_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mc_mask,
    input logic        op_end,
    input logic [4:0]  class_en,
    input logic [4:0]  grant,
    input logic [15:0] mc_code,
    input logic        pend_vld,
    input logic        pend_hard
);
    // R9: never more than one class granted.
    a_r9_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R7: closed mask blocks machine-check grants on the next edge.
    a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !mc_mask |=> (!grant[0] && !grant[2]));

    // R4: a soft check needs the end of the operation.
    a_r4_soft_waits: assert property (@(posedge clk) disable iff (!rst_n)
        !op_end |=> !grant[2]);

    // R3, R5: an allowed pending hard check always wins the next grant.
    a_r5_hard_first: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vld && pend_hard && mc_mask && class_en[0]) |=> grant[0]);

    // R6: a disabled class is never granted.
    a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (class_en != 5'b11111) |=> ((grant & ~$past(class_en)) == 5'b0));

    // R2: upper code bits stay zero on every machine-check grant.
    a_r2_code_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] || grant[2]) |-> (mc_code[15:5] == 11'b0));

    // R1: hard grants carry code 1 or 4.
    a_r1_hard_code: assert property (@(posedge clk) disable iff (!rst_n)
        grant[0] |-> (mc_code[3:0] == 4'd1 || mc_code[3:0] == 4'd4));

    // R1: soft grants carry code 8, 9 or 10.
    a_r1_soft_code: assert property (@(posedge clk) disable iff (!rst_n)
        grant[2] |-> (mc_code[3:0] == 4'd8 || mc_code[3:0] == 4'd9 || mc_code[3:0] == 4'd10));

    // R2: code only moves with a machine-check grant.
    a_r2_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant[0] && !grant[2]) |-> $stable(mc_code) || $past(!rst_n));
endmodule

bind mchk_intr_ctl mchk_intr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mc_mask   (mc_mask),
    .op_end    (op_end),
    .class_en  (class_en),
    .grant     (grant),
    .mc_code   (mc_code),
    .pend_vld  (pend_vld),
    .pend_hard (pend_rec.hard)
);

// File: tb/mchk_intr_ctl_bench.sv
module mchk_intr_ctl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_vld = 1'b0;
    logic [2:0]  err_kind = 3'd0;
    logic        op_end = 1'b0;
    logic        mc_mask = 1'b1;
    logic [4:0]  class_en = 5'b11111;
    logic        req_pgm = 1'b0;
    logic        req_ext = 1'b0;
    logic        req_io = 1'b0;
    logic [4:0]  grant;
    logic [15:0] mc_code;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          at;
        logic [4:0]  g;
        logic [15:0] code;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    mchk_intr_ctl u_mchk_intr_ctl (
        .clk(clk), .rst_n(rst_n), .err_vld(err_vld), .err_kind(err_kind),
        .op_end(op_end), .mc_mask(mc_mask), .class_en(class_en),
        .req_pgm(req_pgm), .req_ext(req_ext), .req_io(req_io),
        .grant(grant), .mc_code(mc_code)
    );

    always @(posedge clk) cyc = cyc + 1;

    task automatic push(input int at, input logic [4:0] g, input logic [15:0] code, input string tag);
        exp_t e;
        e.at = at; e.g = g; e.code = code; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_idle(input string tag);
        checks++;
        if (grant !== 5'b0) begin
            errors++;
            $display("FAIL %s: grant=%b expected=%b", tag, grant, 5'b0);
        end
    endtask

    task automatic check_code(input logic [15:0] e, input string tag);
        checks++;
        if (mc_code !== e) begin
            errors++;
            $display("FAIL %s: mc_code=%h expected=%h", tag, mc_code, e);
        end
    endtask

    // Monitor: pop due items and compare; flag grants nobody expected.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
                checks++; errors++;
                $display("FAIL %s: grant missing, expected=%b", exp_q[0].tag, exp_q[0].g);
                void'(exp_q.pop_front());
            end
            if (exp_q.size() > 0 && exp_q[0].at == cyc) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (grant !== e.g || ((e.g[0] || e.g[2]) && mc_code !== e.code)) begin
                    errors++;
                    $display("FAIL %s: grant=%b code=%h expected grant=%b code=%h",
                             e.tag, grant, mc_code, e.g, e.code);
                end
            end else if (grant !== 5'b0) begin
                checks++; errors++;
                $display("FAIL R9: unexpected grant=%b expected=%b", grant, 5'b0);
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Single report with mask open and op_end high: grant two edges later.
    task automatic one_err(input logic [2:0] k, input logic [4:0] g, input logic [15:0] code, input string tag);
        tick();
        err_vld = 1'b1; err_kind = k;
        push(cyc + 2, g, code, tag);
        tick();
        err_vld = 1'b0;
        repeat (4) tick();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        check_idle("R10 reset grant");
        check_code(16'h0000, "R10 reset code");

        // R1, R3: hard reports, delivered two edges after the report.
        op_end = 1'b1;
        one_err(3'd1, 5'b00001, 16'h0001, "R1 R3 retry exhausted");
        one_err(3'd2, 5'b00001, 16'h0004, "R1 R3 not retriable");
        one_err(3'd7, 5'b00001, 16'h0014, "R1 cpu uncorrectable no retry");
        one_err(3'd6, 5'b00001, 16'h0011, "R1 cpu uncorrectable retry exhausted");
        // R1: soft reports with the operation ending each cycle.
        one_err(3'd0, 5'b00100, 16'h0009, "R1 retry succeeded");
        one_err(3'd4, 5'b00100, 16'h001A, "R1 R2 channel uncorrectable");
        one_err(3'd5, 5'b00100, 16'h0019, "R1 cpu uncorrectable retry ok");

        // R4: soft check deferred until op_end.
        op_end = 1'b0;
        tick();
        err_vld = 1'b1; err_kind = 3'd3;
        tick();
        err_vld = 1'b0;
        repeat (3) tick();
        check_idle("R4 soft held before op_end");
        op_end = 1'b1;
        push(cyc + 1, 5'b00100, 16'h0008, "R4 soft at op_end");
        tick();
        op_end = 1'b0;
        repeat (3) tick();

        // R5: hard beats program, then external, then I/O.
        tick();
        err_vld = 1'b1; err_kind = 3'd1;
        begin
            int c0;
            c0 = cyc;
            push(c0 + 2, 5'b00001, 16'h0001, "R5 hard over program");
            push(c0 + 3, 5'b00010, 16'h0001, "R5 program next");
            push(c0 + 4, 5'b01000, 16'h0001, "R5 external next");
            push(c0 + 5, 5'b10000, 16'h0001, "R5 io last");
        end
        tick();
        err_vld = 1'b0; req_pgm = 1'b1; req_ext = 1'b1; req_io = 1'b1;
        tick();
        tick(); req_pgm = 1'b0;
        tick(); req_ext = 1'b0;
        tick(); req_io = 1'b0;
        repeat (2) tick();
        check_code(16'h0001, "R2 code held across other grants");

        // R5: program beats soft, soft beats external.
        op_end = 1'b1;
        tick();
        err_vld = 1'b1; err_kind = 3'd3;
        begin
            int c1;
            c1 = cyc;
            push(c1 + 2, 5'b00010, 16'h0, "R5 program over soft");
            push(c1 + 3, 5'b00100, 16'h0008, "R5 soft over external");
            push(c1 + 4, 5'b01000, 16'h0, "R5 external after soft");
        end
        tick();
        err_vld = 1'b0; req_pgm = 1'b1; req_ext = 1'b1;
        tick(); req_pgm = 1'b0;
        tick();
        tick(); req_ext = 1'b0;
        repeat (3) tick();

        // R7, R8: masked reports collapse; the hard one is delivered once.
        mc_mask = 1'b0;
        tick(); err_vld = 1'b1; err_kind = 3'd3;
        tick(); err_kind = 3'd1;
        tick(); err_kind = 3'd4;
        tick(); err_vld = 1'b0;
        repeat (3) tick();
        check_idle("R7 nothing while masked");
        mc_mask = 1'b1;
        push(cyc + 1, 5'b00001, 16'h0001, "R8 hard wins collapse");
        repeat (5) tick();

        // R8: first hard kept over a later hard.
        mc_mask = 1'b0;
        tick(); err_vld = 1'b1; err_kind = 3'd2;
        tick(); err_kind = 3'd6;
        tick(); err_vld = 1'b0;
        repeat (2) tick();
        mc_mask = 1'b1;
        push(cyc + 1, 5'b00001, 16'h0004, "R8 first hard kept");
        repeat (5) tick();

        // R8: first soft kept over a later soft.
        mc_mask = 1'b0;
        tick(); err_vld = 1'b1; err_kind = 3'd0;
        tick(); err_kind = 3'd3;
        tick(); err_vld = 1'b0;
        repeat (2) tick();
        check_idle("R7 soft held while masked");
        mc_mask = 1'b1;
        push(cyc + 1, 5'b00100, 16'h0009, "R8 first soft kept");
        repeat (5) tick();

        // R6: disabled classes are skipped.
        class_en = 5'b10101;
        tick();
        req_pgm = 1'b1; req_ext = 1'b1; req_io = 1'b1;
        push(cyc + 1, 5'b10000, 16'h0, "R6 io served past disabled classes");
        tick();
        req_pgm = 1'b0; req_ext = 1'b0; req_io = 1'b0;
        repeat (3) tick();
        class_en = 5'b11110;
        tick(); err_vld = 1'b1; err_kind = 3'd2;
        tick(); err_vld = 1'b0;
        repeat (3) tick();
        check_idle("R6 hard held while class disabled");
        class_en = 5'b11111;
        push(cyc + 1, 5'b00001, 16'h0004, "R6 hard after enable");
        repeat (4) tick();

        // R10: reset drops a pending check and clears the code.
        mc_mask = 1'b0;
        tick(); err_vld = 1'b1; err_kind = 3'd1;
        tick(); err_vld = 1'b0;
        tick(); rst_n = 1'b0;
        tick(); rst_n = 1'b1; mc_mask = 1'b1;
        check_code(16'h0000, "R10 code cleared");
        repeat (4) tick();
        check_idle("R10 pending dropped");

        repeat (3) tick();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R9: %0d grants outstanding, expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule